// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller whose pins are organised in banks of 32. Software programs direction, drives outputs through separate write-only set and clear registers, and reads the conditioned level of every pin. Each pin input passes through a two-flop synchronizer and an optional glitch filter that can be bypassed per pin.

Every pin has its own event detector. It can work in edge mode, with independent rising and falling arms, or in level mode, with a programmable active polarity. Detected events latch into a write-1-to-clear status register. They also latch into a separate wake-source register for pins whose wake mask is set. One combined interrupt line is raised from the status bits whose mask bit is set, across all banks. A combined wake line is raised from any set wake-source bit.

The bus is a flat 32-bit register port: address, write enable, write data, and a read data output that reflects the addressed register in the same cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every control, status and output register reads 0, `pin_oe` and `pin_out` are 0, and `irq_o` and `wake_o` are 0.
- R2: Writing the set group (base 0x034) makes each output bit whose write-data bit is 1 go high, and writing the clear group (base 0x04C) makes it go low. Write-data bits of 0 leave the output unchanged. Both groups read as 0.
- R3: A direction bit (base 0x01C) of 1 drives the matching `pin_oe` bit high (output), and 0 makes the pin an input.
- R4: The level group (base 0x004) reads the conditioned input of every pin of the bank. Writes to it have no effect.
- R5: With the filter-bypass bit (base 0x094) at 1, a pin change that is set up before a clock edge becomes visible after the second edge. With the bypass bit at 0, the change becomes visible only after the fifth edge, once the synchronized value has held for 3 clocks. A pulse lasting 2 clocks is rejected.
- R6: With the input-type bit (base 0x300) at 0 (edge mode), a rising edge sets the status bit only when rising-enable (base 0x064) is 1, and a falling edge sets it only when falling-enable (base 0x07C) is 1. With bypass on, the status bit rises after the third edge following the pin change.
- R7: With the input-type bit at 1 (level mode), the status bit is set while the pin is at its active level. The active level is high when the polarity bit (base 0x318) is 0 and low when it is 1. A clear attempted while the level is still active leaves the bit set.
- R8: Writing 1 to a status bit (base 0x0C4) clears it, and 0 bits are untouched. If a new event arrives in the same cycle as the clear, the bit stays set.
- R9: `irq_o` is 1 exactly when some pin has both its status bit and its mask bit (base 0x0AC, 1 = enabled) set.
- R10: A detected event also sets the wake-source bit (base 0x418), but only when the pin's wake-mask bit (base 0x400) is 1, independent of the interrupt mask. Wake-source bits are write-1-to-clear, and `wake_o` is the OR of all of them.
- R11: Pin n maps to the register at group base + 4 × (n / 32), at bit n % 32. Addresses that hit no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, valid in the same cycle |
| pin_in | input | 32×NUM_BANKS | Raw pin inputs |
| pin_out | output | 32×NUM_BANKS | Output drive values |
| pin_oe | output | 32×NUM_BANKS | Output enables (1 = pin driven) |
| irq_o | output | 1 | Combined interrupt, from masked pending status |
| wake_o | output | 1 | Combined wake request, from any set wake-source bit |

## Verification
A software write-1-to-clear of a status bit can land in the same cycle as a fresh detected edge on that pin. The bench provokes this by raising the pin and issuing the clear write so that its strobe meets the very edge at which the new rise registers. The bit must read 1 afterwards, and a later clear with no event pending must take it to 0. The second overlap is a level-mode pin whose status is cleared while its level is still active: the clear and the re-detection meet in one cycle, and the bit is judged to remain set until the level is withdrawn.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int BANK_W = 32;
    localparam int NUM_KINDS = 14;

    typedef enum logic [3:0] {
        K_NONE = 4'd0,
        K_LVL  = 4'd1,
        K_DIR  = 4'd2,
        K_SET  = 4'd3,
        K_CLR  = 4'd4,
        K_REN  = 4'd5,
        K_FEN  = 4'd6,
        K_BYP  = 4'd7,
        K_MSK  = 4'd8,
        K_STS  = 4'd9,
        K_TYP  = 4'd10,
        K_POL  = 4'd11,
        K_WMK  = 4'd12,
        K_WSR  = 4'd13
    } kind_t;

    // group base offsets; banks follow at 4-byte steps
    function automatic logic [ADDR_W-1:0] kind_base(kind_t k);
        case (k)
            K_LVL:   return 12'h004;
            K_DIR:   return 12'h01C;
            K_SET:   return 12'h034;
            K_CLR:   return 12'h04C;
            K_REN:   return 12'h064;
            K_FEN:   return 12'h07C;
            K_BYP:   return 12'h094;
            K_MSK:   return 12'h0AC;
            K_STS:   return 12'h0C4;
            K_TYP:   return 12'h300;
            K_POL:   return 12'h318;
            K_WMK:   return 12'h400;
            K_WSR:   return 12'h418;
            default: return '0;
        endcase
    endfunction

    typedef struct packed {
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] outv;
        logic [BANK_W-1:0] ren;
        logic [BANK_W-1:0] fen;
        logic [BANK_W-1:0] byp;
        logic [BANK_W-1:0] msk;
        logic [BANK_W-1:0] sts;
        logic [BANK_W-1:0] typ;
        logic [BANK_W-1:0] pol;
        logic [BANK_W-1:0] wmk;
        logic [BANK_W-1:0] wsr;
        logic [BANK_W-1:0] prev;
    } bank_regs_t;

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic bypass,
    output logic cond_out
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             cand;
        logic [CNT_W-1:0] cnt;
        logic             filt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_in;
        st_d.s2 = st_q.s1;
        if (st_q.s2 != st_q.cand) begin
            st_d.cand = st_q.s2;
            st_d.cnt  = CNT_W'(1);
        end else if (st_q.cnt < CNT_W'(FILT_LEN - 1)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else begin
            st_d.filt = st_q.cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cond_out = bypass ? st_q.s2 : st_q.filt;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  kind_t             kind,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BANK_W-1:0] pin_in,
    output logic [DATA_W-1:0] rdata,
    output logic [BANK_W-1:0] pin_out,
    output logic [BANK_W-1:0] pin_oe,
    output logic [BANK_W-1:0] sts_o,
    output logic [BANK_W-1:0] msk_o,
    output logic [BANK_W-1:0] wmk_o,
    output logic [BANK_W-1:0] wsr_o
);
    bank_regs_t        r_d, r_q;
    logic [BANK_W-1:0] cond;
    logic [BANK_W-1:0] rise, fall, lvl_act, evt, clr_sts, clr_wsr;
    logic              wr;

    for (genvar i = 0; i < BANK_W; i++) begin : g_pin
        gpio_in_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (pin_in[i]),
            .bypass   (r_q.byp[i]),
            .cond_out (cond[i])
        );
    end

    assign wr = hit && we;

    always_comb begin
        r_d     = r_q;
        rise    = cond & ~r_q.prev;
        fall    = ~cond & r_q.prev;
        lvl_act = r_q.typ & (cond ^ r_q.pol);
        evt     = lvl_act | (~r_q.typ & ((rise & r_q.ren) | (fall & r_q.fen)));
        clr_sts = (wr && kind == K_STS) ? wdata : '0;
        clr_wsr = (wr && kind == K_WSR) ? wdata : '0;
        r_d.prev = cond;
        if (wr) begin
            case (kind)
                K_DIR:   r_d.dir  = wdata;
                K_SET:   r_d.outv = r_q.outv | wdata;
                K_CLR:   r_d.outv = r_q.outv & ~wdata;
                K_REN:   r_d.ren  = wdata;
                K_FEN:   r_d.fen  = wdata;
                K_BYP:   r_d.byp  = wdata;
                K_MSK:   r_d.msk  = wdata;
                K_TYP:   r_d.typ  = wdata;
                K_POL:   r_d.pol  = wdata;
                K_WMK:   r_d.wmk  = wdata;
                default: ;
            endcase
        end
        // new events win over a clear in the same cycle
        r_d.sts = (r_q.sts & ~clr_sts) | evt;
        r_d.wsr = (r_q.wsr & ~clr_wsr) | (evt & r_q.wmk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (kind)
                K_LVL:   rdata = cond;
                K_DIR:   rdata = r_q.dir;
                K_REN:   rdata = r_q.ren;
                K_FEN:   rdata = r_q.fen;
                K_BYP:   rdata = r_q.byp;
                K_MSK:   rdata = r_q.msk;
                K_STS:   rdata = r_q.sts;
                K_TYP:   rdata = r_q.typ;
                K_POL:   rdata = r_q.pol;
                K_WMK:   rdata = r_q.wmk;
                K_WSR:   rdata = r_q.wsr;
                default: rdata = '0;
            endcase
        end
    end

    assign pin_out = r_q.outv;
    assign pin_oe  = r_q.dir;
    assign sts_o   = r_q.sts;
    assign msk_o   = r_q.msk;
    assign wmk_o   = r_q.wmk;
    assign wsr_o   = r_q.wsr;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int FILT_LEN  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq_o,
    output logic                        wake_o
);
    localparam int NPINS  = NUM_BANKS * BANK_W;
    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    kind_t             dec_kind;
    logic [BIDX_W-1:0] dec_bank;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [NPINS-1:0]  sts_vec, msk_vec, wmk_vec, wsr_vec;

    always_comb begin
        dec_kind = K_NONE;
        dec_bank = '0;
        for (int k = 1; k < NUM_KINDS; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bus_addr == ADDR_W'(32'(kind_base(kind_t'(4'(k)))) + 4 * b)) begin
                    dec_kind = kind_t'(4'(k));
                    dec_bank = BIDX_W'(b);
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.FILT_LEN(FILT_LEN)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (dec_kind != K_NONE && dec_bank == BIDX_W'(b)),
            .kind    (dec_kind),
            .we      (bus_we),
            .wdata   (bus_wdata),
            .pin_in  (pin_in[b*BANK_W +: BANK_W]),
            .rdata   (bank_rd[b]),
            .pin_out (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe  (pin_oe[b*BANK_W +: BANK_W]),
            .sts_o   (sts_vec[b*BANK_W +: BANK_W]),
            .msk_o   (msk_vec[b*BANK_W +: BANK_W]),
            .wmk_o   (wmk_vec[b*BANK_W +: BANK_W]),
            .wsr_o   (wsr_vec[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | bank_rd[b];
    end

    assign irq_o  = |(sts_vec & msk_vec);
    assign wake_o = |wsr_vec;

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [NUM_BANKS*BANK_W-1:0] pin_out,
    input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    input logic                        irq_o,
    input logic [NUM_BANKS*BANK_W-1:0] msk_vec,
    input logic [NUM_BANKS*BANK_W-1:0] wmk_vec,
    input logic [NUM_BANKS*BANK_W-1:0] wsr_vec
);
    logic wr_dir_grp, wr_out_grp, wr_set0, wr_clr0;

    assign wr_dir_grp = bus_we && bus_addr >= kind_base(K_DIR) && bus_addr < kind_base(K_SET);
    assign wr_out_grp = bus_we && bus_addr >= kind_base(K_SET) && bus_addr < kind_base(K_REN);
    assign wr_set0    = bus_we && bus_addr == kind_base(K_SET);
    assign wr_clr0    = bus_we && bus_addr == kind_base(K_CLR);

    assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir_grp |=> $stable(pin_oe));

    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out_grp |=> $stable(pin_out));

    assert_set_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set0 |=> ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr0 |=> ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == '0));

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_vec == '0) |-> !irq_o);

    assert_wake_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((wsr_vec & ~$past(wsr_vec) & ~$past(wmk_vec)) == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_o     (irq_o),
    .msk_vec   (msk_vec),
    .wmk_vec   (wmk_vec),
    .wsr_vec   (wsr_vec)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
    localparam int NB = 2;
    localparam int NP = NB * 32;

    localparam logic [11:0] A_LVL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034,
                            A_CLR = 12'h04C, A_REN = 12'h064, A_FEN = 12'h07C,
                            A_BYP = 12'h094, A_MSK = 12'h0AC, A_STS = 12'h0C4,
                            A_TYP = 12'h300, A_POL = 12'h318, A_WMK = 12'h400,
                            A_WSR = 12'h418;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq_o, wake_o;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        chk("R1 irq_o", irq_o, 0);
        chk("R1 wake_o", wake_o, 0);
        peek(A_DIR, rv); chk("R1 dir", rv, 0);
        peek(A_MSK, rv); chk("R1 mask", rv, 0);
        peek(A_TYP, rv); chk("R1 type", rv, 0);
        peek(A_STS, rv); chk("R1 status", rv, 0);
    endtask

    task automatic t_output;
        wr(A_DIR, 32'h0000_00FF);
        chk("R3 oe bank0", pin_oe[31:0], 32'h0000_00FF);
        wr(A_SET, 32'h0000_000F);
        chk("R2 set", pin_out[31:0], 32'h0000_000F);
        wr(A_SET, 32'h0);
        chk("R2 set zero no effect", pin_out[31:0], 32'h0000_000F);
        wr(A_CLR, 32'h0000_0005);
        chk("R2 clear", pin_out[31:0], 32'h0000_000A);
        peek(A_SET, rv); chk("R2 set reads 0", rv, 0);
        peek(A_CLR, rv); chk("R2 clear reads 0", rv, 0);
        wr(A_SET + 12'h4, 32'h0000_0008);
        chk("R11 bank1 set pin35", pin_out, 64'h0000_0008_0000_000A);
        wr(A_DIR, 32'h0);
        chk("R3 back to input", pin_oe[31:0], 32'h0);
    endtask

    task automatic t_level;
        wr(A_BYP, 32'hFFFF_FFFF);
        pin_in = 64'h8000_0001_0000_00A0;
        step(8);
        peek(A_LVL, rv); chk("R4 level bank0", rv, 32'h0000_00A0);
        peek(A_LVL + 12'h4, rv); chk("R11 level bank1", rv, 32'h8000_0001);
        wr(A_LVL, 32'h0);
        peek(A_LVL, rv); chk("R4 level write ignored", rv, 32'h0000_00A0);
        peek(12'h010, rv); chk("R11 unmapped reads 0", rv, 0);
        pin_in = '0;
        step(8);
    endtask

    task automatic t_filter;
        wr(A_BYP, 32'hFFFF_FEFF);   // pin 8 filtered, pin 9 bypassed
        pin_in[8] = 1'b1;
        step(2);
        pin_in[8] = 1'b0;
        step(6);
        peek(A_LVL, rv); chk("R5 2-clock glitch rejected", rv[8], 0);
        pin_in[8] = 1'b1; pin_in[9] = 1'b1;
        step(1);
        peek(A_LVL, rv); chk("R5 bypass not yet", rv[9], 0);
        step(1);
        peek(A_LVL, rv); chk("R5 bypass after 2 edges", rv[9], 1);
        step(2);
        peek(A_LVL, rv); chk("R5 filter after 4 edges", rv[8], 0);
        step(1);
        peek(A_LVL, rv); chk("R5 filter after 5 edges", rv[8], 1);
        pin_in[9:8] = 2'b00;
        wr(A_BYP, 32'hFFFF_FFFF);
        step(8);
    endtask

    task automatic t_edge;
        wr(A_MSK, 32'h1);
        wr(A_REN, 32'h1);
        wr(A_FEN, 32'h2);
        pin_in[0] = 1'b1;
        step(2);
        peek(A_STS, rv); chk("R6 status not before 3rd edge", rv[0], 0);
        step(1);
        peek(A_STS, rv); chk("R6 rise sets status", rv[0], 1);
        chk("R9 irq masked-in", irq_o, 1);
        pin_in[0] = 1'b0;
        step(4);
        wr(A_STS, 32'h1);
        peek(A_STS, rv); chk("R8 w1c clears", rv, 0);
        chk("R9 irq drops", irq_o, 0);
        pin_in[1] = 1'b1;
        step(4);
        peek(A_STS, rv); chk("R6 rise not armed", rv[1], 0);
        pin_in[1] = 1'b0;
        step(4);
        peek(A_STS, rv); chk("R6 fall sets status", rv[1], 1);
        chk("R9 status unmasked no irq", irq_o, 0);
        wr(A_MSK, 32'h3);
        chk("R9 mask enables irq", irq_o, 1);
        wr(A_STS, 32'h0);
        peek(A_STS, rv); chk("R8 zero write keeps", rv[1], 1);
        wr(A_STS, 32'h3);
        wr(A_MSK, 32'h0);
        wr(A_REN, 32'h0);
        wr(A_FEN, 32'h0);
    endtask

    task automatic t_level_irq;
        wr(A_POL, 32'h0);
        wr(A_TYP, 32'h4);
        pin_in[2] = 1'b1;
        step(4);
        peek(A_STS, rv); chk("R7 active-high sets", rv[2], 1);
        wr(A_STS, 32'h4);
        peek(A_STS, rv); chk("R7 clear while active holds", rv[2], 1);
        pin_in[2] = 1'b0;
        step(4);
        wr(A_STS, 32'h4);
        peek(A_STS, rv); chk("R7 clear after inactive", rv[2], 0);
        wr(A_POL, 32'h4);
        step(1);
        peek(A_STS, rv); chk("R7 active-low sets", rv[2], 1);
        pin_in[2] = 1'b1;
        step(4);
        wr(A_STS, 32'h4);
        peek(A_STS, rv); chk("R7 active-low released", rv[2], 0);
        wr(A_TYP, 32'h0);
        wr(A_POL, 32'h0);
        pin_in[2] = 1'b0;
        step(4);
        wr(A_STS, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide;
        wr(A_REN, 32'h8);
        pin_in[3] = 1'b1;
        step(4);
        pin_in[3] = 1'b0;
        step(4);
        peek(A_STS, rv); chk("R8 pre-collision set", rv[3], 1);
        pin_in[3] = 1'b1;
        step(2);
        wr(A_STS, 32'h8);   // strobe meets the edge where the new rise registers
        peek(A_STS, rv); chk("R8 event beats clear", rv[3], 1);
        wr(A_STS, 32'h8);
        peek(A_STS, rv); chk("R8 later clear works", rv[3], 0);
        pin_in[3] = 1'b0;
        wr(A_REN, 32'h0);
        step(4);
    endtask

    task automatic t_wake;
        wr(A_WMK, 32'h20);
        wr(A_REN, 32'h60);
        pin_in[6:5] = 2'b11;
        step(4);
        chk("R10 wake_o set", wake_o, 1);
        peek(A_WSR, rv); chk("R10 only masked pin", rv, 32'h20);
        chk("R10 independent of irq mask", irq_o, 0);
        wr(A_WSR, 32'h20);
        chk("R10 w1c wake", wake_o, 0);
        wr(A_STS, 32'h60);
        wr(A_REN, 32'h0);
        wr(A_WMK, 32'h0);
        pin_in[6:5] = 2'b00;
        step(4);
    endtask

    task automatic t_bank1;
        wr(A_REN + 12'h4, 32'h100);
        wr(A_MSK + 12'h4, 32'h100);
        pin_in[40] = 1'b1;
        step(10);
        peek(A_STS + 12'h4, rv); chk("R11 pin40 in bank1 bit8", rv, 32'h100);
        peek(A_STS, rv); chk("R11 bank0 untouched", rv, 0);
        chk("R11 R9 irq from bank1", irq_o, 1);
        wr(A_STS + 12'h4, 32'h100);
        chk("R9 irq cleared", irq_o, 0);
    endtask

    initial begin : watchdog
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_output();
        t_level();
        t_filter();
        t_edge();
        t_level_irq();
        t_collide();
        t_wake();
        t_bank1();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule